// File: doc/BRIEF.md
# Infrared Interaction Pulse Sequencer

This block owns the serial output pin of a high-speed infrared transmitter whenever no frame is being sent. When the transmitter is enabled, and again after every completed frame, it sends one interaction pulse with a fixed shape: a short high time followed by a longer low time, 9 µs in total. Slow-rate stations on the link read this pulse as a start bit and stay quiet. After the pulse it sends a repeating idle preamble. It hands the line to the frame encoder only at a pattern boundary, once the transmit FIFO reports data.

All timing runs on a timebase tick that is qualified onto the system clock. One tick is one chip, at 8 MHz by default. A watchdog counts ticks since the last pulse. If the configured interval (500 ms by default) passes with no pulse, it raises a sticky violation flag. When the transmitter is disabled, the block stops driving the line in the same cycle, releases pin ownership and gates the transmit clock.

Top module: `ir_sip_seq`

## Requirements
- R1: While tx_en_i is low, txd_o, pin_own_o and tx_clk_en_o are all low; they drop in the same cycle tx_en_i falls.
- R2: In the first cycle after tx_en_i rises, a pulse starts: txd_o is high for PULSE_HI ticks and then low for PULSE_LO ticks (defaults 13 and 59).
- R3: A frame_done_i strobe while the line carries data starts a new pulse in the next cycle.
- R4: After the pulse, the preamble PREAMBLE (default 16'b1000_0000_1010_1000) repeats on txd_o, most significant chip first, one chip per tick.
- R5: Once fifo_ne_i has been seen during the preamble, the switch to data happens only after the last chip of the pattern. data_start_o is high for exactly the first data cycle, and txd_o then follows enc_chip_i.
- R6: frame_done_i has no effect while the pulse or the preamble is on the line.
- R7: When tick_i is low, the sequence does not advance.
- R8: wd_viol_o is set when WD_TICKS ticks pass with no pulse start. The count restarts at every pulse start and is held at zero while disabled.
- R9: wd_viol_o stays set until wd_clr_i is asserted.
- R10: While the transmitter is enabled, pin_own_o and tx_clk_en_o are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | system clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | timebase tick, one chip per pulse |
| tx_en_i | input | 1 | transmitter enable |
| frame_done_i | input | 1 | end-of-frame strobe from the encoder |
| fifo_ne_i | input | 1 | transmit FIFO holds data |
| enc_chip_i | input | 1 | encoded chip from the frame encoder |
| wd_clr_i | input | 1 | clears the interval violation flag |
| txd_o | output | 1 | serial infrared line |
| pin_own_o | output | 1 | block owns the pin |
| tx_clk_en_o | output | 1 | transmit clock enable |
| data_start_o | output | 1 | one-cycle strobe at the start of data |
| wd_viol_o | output | 1 | sticky pulse-interval violation |

## Verification
A wrong pulse counter or a wrong state shows up on txd_o within one tick. It appears either as a high chip where a low one belongs or as a pulse that is too short or too long. The bench therefore samples the line at the exact tick edges of the pulse and of each preamble chip. A broken preamble boundary shows up as a data_start_o strobe one or more ticks early or late. A watchdog fault shows up only at the interval edge, so the flag is checked one tick before the limit and at the limit. It is also checked after an intervening pulse, which must move the limit.

// File: rtl/ir_sip_pkg.sv
package ir_sip_pkg;
  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_PULSE = 2'd1,
    ST_PREAM = 2'd2,
    ST_DATA  = 2'd3
  } seq_state_e;
endpackage

// File: rtl/ir_sip_pattern.sv
module ir_sip_pattern #(
  parameter int unsigned            PRE_LEN  = 16,
  parameter logic [PRE_LEN-1:0]     PREAMBLE = 16'b1000_0000_1010_1000,
  localparam int unsigned           CHIP_W   = $clog2(PRE_LEN)
) (
  input  logic [CHIP_W-1:0] chip_idx_i,
  output logic              chip_o
);
  logic [PRE_LEN-1:0] order;

  // chip index 0 is the pattern MSB
  for (genvar g = 0; g < PRE_LEN; g++) begin : g_ord
    assign order[g] = PREAMBLE[PRE_LEN-1-g];
  end

  assign chip_o = order[chip_idx_i];
endmodule

// File: rtl/ir_sip_fsm.sv
module ir_sip_fsm
  import ir_sip_pkg::*;
#(
  parameter int unsigned PULSE_HI = 13,
  parameter int unsigned PULSE_LO = 59,
  parameter int unsigned PRE_LEN  = 16,
  localparam int unsigned PULSE_TOT = PULSE_HI + PULSE_LO,
  localparam int unsigned CNT_W     = $clog2(PULSE_TOT),
  localparam int unsigned CHIP_W    = $clog2(PRE_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              tx_en_i,
  input  logic              frame_done_i,
  input  logic              fifo_ne_i,
  output seq_state_e        state_o,
  output logic [CNT_W-1:0]  pulse_cnt_o,
  output logic [CHIP_W-1:0] chip_idx_o,
  output logic              pulse_go_o,
  output logic              data_start_o
);
  localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(PULSE_TOT - 1);
  localparam logic [CHIP_W-1:0] CHIP_LAST = CHIP_W'(PRE_LEN - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CHIP_W-1:0] chip_q, chip_d;
  logic              pend_q, pend_d;
  logic              ds_q, ds_d;

  assign pulse_go_o = tx_en_i &&
                      ((state_q == ST_OFF) || (state_q == ST_DATA && frame_done_i));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    chip_d  = chip_q;
    pend_d  = pend_q;
    ds_d    = 1'b0;
    if (!tx_en_i) begin
      state_d = ST_OFF;
      cnt_d   = '0;
      chip_d  = '0;
      pend_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_PULSE;
          cnt_d   = '0;
        end
        ST_PULSE: begin
          if (tick_i) begin
            if (cnt_q == CNT_LAST) begin
              state_d = ST_PREAM;
              chip_d  = '0;
              pend_d  = 1'b0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_PREAM: begin
          if (fifo_ne_i) pend_d = 1'b1;
          if (tick_i) begin
            if (chip_q == CHIP_LAST) begin
              chip_d = '0;
              if (pend_q || fifo_ne_i) begin
                state_d = ST_DATA;
                pend_d  = 1'b0;
                ds_d    = 1'b1;
              end
            end else begin
              chip_d = chip_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (frame_done_i) begin
            state_d = ST_PULSE;
            cnt_d   = '0;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
      chip_q  <= '0;
      pend_q  <= 1'b0;
      ds_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      chip_q  <= chip_d;
      pend_q  <= pend_d;
      ds_q    <= ds_d;
    end
  end

  assign state_o      = state_q;
  assign pulse_cnt_o  = cnt_q;
  assign chip_idx_o   = chip_q;
  assign data_start_o = ds_q;

  p_dis_off_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> state_q == ST_OFF);

  p_en_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OFF && tx_en_i) |=> (state_q == ST_PULSE && cnt_q == '0));

  p_frame_ign_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PREAM && tx_en_i && frame_done_i) |=> state_q != ST_PULSE);

  p_ds_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_start_o |=> !data_start_o);

  p_ds_boundary_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_start_o |-> ($past(chip_q) == CHIP_LAST && $past(state_q) == ST_PREAM));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && tx_en_i && state_q == ST_PULSE) |=> $stable(cnt_q));
endmodule

// File: rtl/ir_sip_wdog.sv
module ir_sip_wdog #(
  parameter int unsigned WD_TICKS = 4_000_000,
  localparam int unsigned WD_W    = $clog2(WD_TICKS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic pulse_go_i,
  input  logic clr_i,
  output logic viol_o
);
  localparam logic [WD_W-1:0] WD_LAST = WD_W'(WD_TICKS - 1);

  logic [WD_W-1:0] cnt_q;
  logic            viol_q;
  logic            hit;

  assign hit = en_i && !pulse_go_i && tick_i && (cnt_q == WD_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || pulse_go_i || hit) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      viol_q <= 1'b0;
    else if (hit)     viol_q <= 1'b1;
    else if (clr_i)   viol_q <= 1'b0;
  end

  assign viol_o = viol_q;

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (viol_q && !clr_i) |=> viol_q);

  p_cnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= WD_LAST);

  p_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_go_i |=> cnt_q == '0);
endmodule

// File: rtl/ir_sip_seq.sv
module ir_sip_seq
  import ir_sip_pkg::*;
#(
  parameter int unsigned        PULSE_HI = 13,
  parameter int unsigned        PULSE_LO = 59,
  parameter int unsigned        PRE_LEN  = 16,
  parameter logic [PRE_LEN-1:0] PREAMBLE = 16'b1000_0000_1010_1000,
  parameter int unsigned        WD_TICKS = 4_000_000,
  localparam int unsigned       CNT_W    = $clog2(PULSE_HI + PULSE_LO),
  localparam int unsigned       CHIP_W   = $clog2(PRE_LEN)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tx_en_i,
  input  logic frame_done_i,
  input  logic fifo_ne_i,
  input  logic enc_chip_i,
  input  logic wd_clr_i,
  output logic txd_o,
  output logic pin_own_o,
  output logic tx_clk_en_o,
  output logic data_start_o,
  output logic wd_viol_o
);
  seq_state_e        state;
  logic [CNT_W-1:0]  pulse_cnt;
  logic [CHIP_W-1:0] chip_idx;
  logic              pulse_go;
  logic              pre_chip;
  logic              line;

  ir_sip_fsm #(
    .PULSE_HI(PULSE_HI), .PULSE_LO(PULSE_LO), .PRE_LEN(PRE_LEN)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .tx_en_i      (tx_en_i),
    .frame_done_i (frame_done_i),
    .fifo_ne_i    (fifo_ne_i),
    .state_o      (state),
    .pulse_cnt_o  (pulse_cnt),
    .chip_idx_o   (chip_idx),
    .pulse_go_o   (pulse_go),
    .data_start_o (data_start_o)
  );

  ir_sip_pattern #(.PRE_LEN(PRE_LEN), .PREAMBLE(PREAMBLE)) u_pat (
    .chip_idx_i (chip_idx),
    .chip_o     (pre_chip)
  );

  ir_sip_wdog #(.WD_TICKS(WD_TICKS)) u_wd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick_i),
    .en_i       (tx_en_i),
    .pulse_go_i (pulse_go),
    .clr_i      (wd_clr_i),
    .viol_o     (wd_viol_o)
  );

  always_comb begin
    unique case (state)
      ST_PULSE: line = (pulse_cnt < CNT_W'(PULSE_HI));
      ST_PREAM: line = pre_chip;
      ST_DATA:  line = enc_chip_i;
      default:  line = 1'b0;
    endcase
  end

  // disable cuts the line in the same cycle
  assign txd_o       = tx_en_i & line;
  assign pin_own_o   = tx_en_i & (state != ST_OFF);
  assign tx_clk_en_o = pin_own_o;

  p_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> !tx_clk_en_o);

  p_own_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && $past(tx_en_i)) |-> pin_own_o);
endmodule

// File: tb/tb_ir_sip_seq.sv
module tb_ir_sip_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1, en = 1'b0, fdone = 1'b0, fne = 1'b0, enc = 1'b0, wclr = 1'b0;
  logic txd, own, clken, dstart, viol;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ir_sip_seq #(.WD_TICKS(500)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tx_en_i(en),
    .frame_done_i(fdone), .fifo_ne_i(fne), .enc_chip_i(enc), .wd_clr_i(wclr),
    .txd_o(txd), .pin_own_o(own), .tx_clk_en_o(clken),
    .data_start_o(dstart), .wd_viol_o(viol)
  );

  localparam int NV = 13;
  // offsets in cycles after the enable edge, expected txd (R2, R4)
  localparam int OFFS [NV] = '{0, 12, 13, 71, 72, 73, 80, 81, 82, 84, 85, 87, 88};
  localparam bit EXPB [NV] = '{1,  1,  0,  0,  1,  0,  1,  0,  1,  1,  0,  0,  1};

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog timeout");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cur;
    step(3);
    chk("R1 reset txd", txd, 1'b0);
    chk("R1 reset own", own, 1'b0);
    chk("R1 reset clken", clken, 1'b0);
    chk("R5 reset dstart", dstart, 1'b0);
    chk("R9 reset viol", viol, 1'b0);
    rst_n = 1'b1;
    step(1);
    en = 1'b1; enc = 1'b1;
    step(1); // enable edge E0
    cur = 0;
    for (int i = 0; i < NV; i++) begin
      step(OFFS[i] - cur);
      cur = OFFS[i];
      chk(i < 4 ? "R2 pulse" : "R4 preamble", txd, EXPB[i]);
    end
    chk("R10 own", own, 1'b1);
    chk("R10 clken", clken, 1'b1);
    step(90 - cur); cur = 90;
    fne = 1'b1;
    step(103 - cur); cur = 103;
    chk("R5 no early start", dstart, 1'b0);
    chk("R5 last chip", txd, 1'b0);
    step(1); cur = 104;
    chk("R5 data start", dstart, 1'b1);
    chk("R5 follows enc", txd, 1'b1);
    enc = 1'b0; #1;
    chk("R5 follows enc low", txd, 1'b0);
    step(1); cur = 105;
    chk("R5 strobe one cycle", dstart, 1'b0);
    step(110 - cur); cur = 110;
    fdone = 1'b1;
    step(1); cur = 111; // F
    fdone = 1'b0; fne = 1'b0;
    chk("R3 pulse after frame", txd, 1'b1);
    step(12);
    chk("R3 pulse high end", txd, 1'b1);
    step(1);
    chk("R3 pulse low", txd, 1'b0);
    step(74 - 13); // F+74, chip 2
    fdone = 1'b1;
    step(1); // F+75
    fdone = 1'b0;
    chk("R6 frame ignored", txd, 1'b0);
    step(1);
    chk("R6 frame ignored 2", txd, 1'b0);
    step(12); // F+88 chip 0
    chk("R4 wrap chip0", txd, 1'b1);
    en = 1'b0; #1;
    chk("R1 txd cut", txd, 1'b0);
    chk("R1 own drop", own, 1'b0);
    chk("R1 clken drop", clken, 1'b0);
    step(3);
    chk("R1 stays low", txd, 1'b0);
    // R7 tick hold
    tick = 1'b0; en = 1'b1;
    step(1);
    chk("R2 pulse on enable", txd, 1'b1);
    step(30);
    chk("R7 hold high", txd, 1'b1);
    tick = 1'b1;
    step(12);
    chk("R7 resumed high", txd, 1'b1);
    step(1);
    chk("R7 resumed low", txd, 1'b0);
    en = 1'b0;
    step(3);
    // R8 / R9 watchdog, data held so no pulse
    fne = 1'b1; en = 1'b1;
    step(1); cur = 0;
    step(88); cur = 88;
    chk("R5 start after fresh enable", dstart, 1'b1);
    step(200 - cur); cur = 200;
    fdone = 1'b1;
    step(1); cur = 201;
    fdone = 1'b0;
    step(500 - cur); cur = 500;
    chk("R8 restart by pulse", viol, 1'b0);
    step(700 - cur); cur = 700;
    chk("R8 before limit", viol, 1'b0);
    step(1); cur = 701;
    chk("R8 at limit", viol, 1'b1);
    step(3); cur = 704;
    chk("R9 sticky", viol, 1'b1);
    wclr = 1'b1;
    step(1);
    wclr = 1'b0;
    chk("R9 cleared", viol, 1'b0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule